// File: doc/BRIEF.md
# Sleep-Mode Wake Qualifier

This block decides whether a node in a low-power state has received a genuine wake request. It watches two inputs: the digitized level of the single-wire bus, where 1 is recessive and 0 is dominant, and an active-low local wake pin driven by an external switch. Both inputs arrive asynchronously and pass through a synchronizer chain before any filtering. The mode controller enables detection with `armed`. While `armed` is low, both detection paths are held cleared.

A remote wake needs a complete recessive, then dominant, then recessive sequence. The dominant phase must last at least `bus_min_cycles` samples, and the wake is raised when the bus returns to recessive. A bus that stays dominant, for example because it is shorted to ground, therefore never wakes the node. A local wake is raised once the pin has been low for more than `pin_min_cycles` samples. Only one wake is raised per press. Each wake appears on `wake_pulse` as a single-cycle pulse. Both thresholds are run-time inputs counted in clock cycles, so the 25 µs to 150 µs filter window (50 µs nominal) can be matched to any clock frequency.

Top module: `wake_qualifier`

## Requirements
- R1: While reset is applied, and in the first cycles after reset is released, `wake_pulse` is 0.
- R2: When the bus has been recessive and then stays dominant for at least `bus_min_cycles` synchronized samples before returning to recessive, exactly one wake cycle is produced. `wake_pulse` rises after the third rising clock edge that samples the raw input back at recessive (1).
- R3: A dominant run shorter than `bus_min_cycles` samples produces no wake. The path then restarts its count at the next recessive-to-dominant transition.
- R4: A bus held dominant produces no wake for as long as it stays dominant, however long that is.
- R5: A remote wake starts only on a recessive-to-dominant transition. If the bus is already dominant when `armed` rises, its later return to recessive produces no wake.
- R6: A local wake is produced when `wake_pin_n` has been low for more than `pin_min_cycles` samples. `wake_pulse` rises after the rising edge that takes the (`pin_min_cycles`+3)th sample of the raw low level. A low run of exactly `pin_min_cycles` samples, or fewer, produces nothing.
- R7: A pin held low produces exactly one wake. The path produces another wake only after the pin has gone high and then been held low long enough again.
- R8: While `armed` is low, `wake_pulse` stays 0 and both paths clear their progress. A dominant run that is interrupted by disarming does not count toward a wake after re-arming.
- R9: Each wake event drives `wake_pulse` high for exactly one clock cycle.
- R10: The thresholds act at run time. Changing `bus_min_cycles` while disarmed moves the qualifying dominant length to the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| armed | input | 1 | Detection enable from the mode controller, synchronous to clk |
| bus_level | input | 1 | Asynchronous bus level: 1 recessive, 0 dominant |
| wake_pin_n | input | 1 | Asynchronous local wake pin, active low |
| bus_min_cycles | input | CNT_W | Minimum dominant length for a remote wake, in clock cycles |
| pin_min_cycles | input | CNT_W | The local pin must stay low longer than this many cycles |
| wake_pulse | output | 1 | Single-cycle pulse for each qualified wake |

## Verification
Dominant runs are applied one cycle below, exactly at, and well above the bus threshold. These separate a correct at-least comparison from an off-by-one, and show that a too-short run leaves nothing behind. Local-pin runs are applied at the threshold and one cycle above it, which separates the strict more-than rule from at-least. A long hold on the pin shows that only one wake is raised per press. Three further patterns target the sequence rule rather than the pulse width: a stuck-dominant bus, a bus that is already dominant when detection is armed, and a dominant run cut by disarming. Exact-latency checks and a changed threshold fix when the pulse appears and confirm that the limits take effect at run time.

// File: rtl/wake_qualifier_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the wake qualifier.
// Assumes: the bus level is encoded as 1 = recessive and 0 = dominant.
package wake_qualifier_pkg;
    localparam logic LVL_RECESSIVE = 1'b1;
    localparam logic LVL_DOMINANT  = 1'b0;

    // Progress of the remote wake sequence.
    typedef enum logic [1:0] {
        BW_WAIT_REC = 2'd0,  // waiting for a first recessive level
        BW_REC      = 2'd1,  // recessive seen, watching for a falling transition
        BW_DOM      = 2'd2,  // dominant, counting toward the threshold
        BW_HELD     = 2'd3   // threshold met, waiting for the return to recessive
    } bus_wake_st_e;
endpackage

// File: rtl/wq_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a vector of independent asynchronous bits.
// Assumes: each bit is a slow level signal, so per-bit capture is safe.
// The reset value is chosen per bit so that an input reads as inactive after reset.
module wq_sync #(
    parameter int              WIDTH   = 2,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // The first stage captures the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= async_i;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage re-registers the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/wq_bus_path.sv
`timescale 1ns/1ps
// Remote wake path: qualifies a recessive-dominant-recessive sequence on the bus.
// Assumes: bus_dom_i is already synchronized. lim_i is held steady while armed.
// A limit of 0 behaves like 1. The wake pulse is issued on the return to recessive.
module wq_bus_path
    import wake_qualifier_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed_i,
    input  logic             bus_dom_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             wake_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    bus_wake_st_e     st_q;
    logic [CNT_W-1:0] cnt_q;

    // Sequence tracker and dominant-length counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed_i) begin
            st_q   <= BW_WAIT_REC;
            cnt_q  <= '0;
            wake_o <= 1'b0;
        end else begin
            wake_o <= 1'b0;
            unique case (st_q)
                BW_WAIT_REC: if (!bus_dom_i) st_q <= BW_REC;
                BW_REC: if (bus_dom_i) begin
                    cnt_q <= ONE;
                    st_q  <= (lim_i <= ONE) ? BW_HELD : BW_DOM;
                end
                BW_DOM: if (!bus_dom_i) begin
                    cnt_q <= '0;
                    st_q  <= BW_REC;
                end else begin
                    cnt_q <= cnt_q + ONE;
                    if (cnt_q + ONE >= lim_i) st_q <= BW_HELD;
                end
                BW_HELD: if (!bus_dom_i) begin
                    wake_o <= 1'b1;
                    cnt_q  <= '0;
                    st_q   <= BW_REC;
                end
                default: st_q <= BW_WAIT_REC;
            endcase
        end
    end

    // R9: a remote wake lasts a single cycle.
    assert_bus_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);
    // R2: a remote wake follows a recessive sample.
    assert_bus_wake_on_recessive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> !$past(bus_dom_i));
    // R4: two dominant samples in a row never yield a wake.
    assert_no_wake_while_dominant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_dom_i && $past(bus_dom_i)) |=> !wake_o);
    // R3: a dominant run still being counted stays below the threshold.
    assert_dom_count_below_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BW_DOM) |-> (cnt_q < lim_i));
    // R8: disarming silences the path.
    assert_bus_disarmed_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_i |=> !wake_o);
endmodule

// File: rtl/wq_pin_path.sv
`timescale 1ns/1ps
// Local wake path: raises one wake when the pin stays low beyond the limit.
// Assumes: pin_low_i is already synchronized. A wake needs more than lim_i low samples.
// After a wake the path waits for the pin to go high before it can wake again.
module wq_pin_path #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed_i,
    input  logic             pin_low_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             wake_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             fired_q;

    // Low-time counter with a one-wake-per-press latch.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed_i) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
            wake_o  <= 1'b0;
        end else begin
            wake_o <= 1'b0;
            if (!pin_low_i) begin
                cnt_q   <= '0;
                fired_q <= 1'b0;
            end else if (!fired_q) begin
                if (cnt_q >= lim_i) begin
                    wake_o  <= 1'b1;
                    fired_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R7: a press yields a single-cycle wake and no repeat.
    assert_pin_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);
    // R6: a local wake follows a low sample of the pin.
    assert_pin_wake_on_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(pin_low_i));
    // R8: disarming silences the path.
    assert_pin_disarmed_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_i |=> !wake_o);
endmodule

// File: rtl/wake_qualifier.sv
`timescale 1ns/1ps
// Sleep-mode wake qualifier: synchronizes the bus level and the local pin, filters each,
// and merges the two wake sources into a single pulse output.
// Assumes: armed and the limits are synchronous to clk, and the limits change only while disarmed.
module wake_qualifier
    import wake_qualifier_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             bus_level,
    input  logic             wake_pin_n,
    input  logic [CNT_W-1:0] bus_min_cycles,
    input  logic [CNT_W-1:0] pin_min_cycles,
    output logic             wake_pulse
);
    localparam int IN_W = 2;

    logic [IN_W-1:0] raw_in, sync_in;
    logic            bus_wake, pin_wake;

    assign raw_in = {wake_pin_n, bus_level};

    wq_sync #(
        .WIDTH  (IN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL({1'b1, LVL_RECESSIVE})
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw_in),
        .sync_o (sync_in)
    );

    wq_bus_path #(.CNT_W(CNT_W)) i_bus_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed_i  (armed),
        .bus_dom_i(sync_in[0] == LVL_DOMINANT),
        .lim_i    (bus_min_cycles),
        .wake_o   (bus_wake)
    );

    wq_pin_path #(.CNT_W(CNT_W)) i_pin_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed_i  (armed),
        .pin_low_i(!sync_in[1]),
        .lim_i    (pin_min_cycles),
        .wake_o   (pin_wake)
    );

    assign wake_pulse = bus_wake | pin_wake;

    // R1: no wake while reset is applied, observed on the next cycle.
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !wake_pulse);
    // R8: the merged output stays low while disarmed.
    assert_top_disarmed_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !wake_pulse);
endmodule

// File: tb/test_wake_qualifier.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table of pulse patterns, then directed corner cases.
module test_wake_qualifier;
    localparam int CNT_W = 16;
    localparam int BUS_LIM = 8;
    localparam int PIN_LIM = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic armed = 1'b0;
    logic bus_level = 1'b1;
    logic wake_pin_n = 1'b1;
    logic [CNT_W-1:0] bus_min_cycles = CNT_W'(BUS_LIM);
    logic [CNT_W-1:0] pin_min_cycles = CNT_W'(PIN_LIM);
    logic wake_pulse;

    int n_checks = 0;
    int n_fail = 0;
    int seen = 0;
    bit counting = 1'b0;

    always #2.5 clk = ~clk;

    wake_qualifier #(.CNT_W(CNT_W)) i_wake_qualifier (
        .clk(clk), .rst_n(rst_n), .armed(armed), .bus_level(bus_level),
        .wake_pin_n(wake_pin_n), .bus_min_cycles(bus_min_cycles),
        .pin_min_cycles(pin_min_cycles), .wake_pulse(wake_pulse)
    );

    // Count the cycles in which the wake output is high, sampled mid-cycle.
    always @(negedge clk) if (counting && wake_pulse) seen++;

    // kind: 0 = dominant bus run, then recessive; 1 = low pin run, then release.
    typedef struct packed {
        logic [1:0]  kind;
        logic [15:0] len;
        logic [3:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'd8,  4'd1, 4'd2},  // R2 exactly at the bus limit
        '{2'd0, 16'd7,  4'd0, 4'd3},  // R3 one cycle short
        '{2'd0, 16'd1,  4'd0, 4'd3},  // R3 glitch
        '{2'd0, 16'd30, 4'd1, 4'd2},  // R2 long dominant run
        '{2'd0, 16'd9,  4'd1, 4'd9},  // R9 wake lasts one cycle
        '{2'd1, 16'd7,  4'd1, 4'd6},  // R6 one above the pin limit
        '{2'd1, 16'd6,  4'd0, 4'd6},  // R6 exactly at the pin limit
        '{2'd1, 16'd2,  4'd0, 4'd6},  // R6 glitch
        '{2'd1, 16'd40, 4'd1, 4'd7},  // R7 long press, one wake
        '{2'd1, 16'd7,  4'd1, 4'd7}   // R7 second press wakes again
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_run(input int n);
        @(negedge clk) bus_level = 1'b0;
        repeat (n) @(negedge clk);
        bus_level = 1'b1;
    endtask

    task automatic pin_run(input int n);
        @(negedge clk) wake_pin_n = 1'b0;
        repeat (n) @(negedge clk);
        wake_pin_n = 1'b1;
    endtask

    task automatic open_window();
        @(negedge clk);
        seen = 0;
        counting = 1'b1;
    endtask

    task automatic close_window();
        repeat (10) @(negedge clk);
        counting = 1'b0;
    endtask

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        check("R1 during reset", int'(wake_pulse), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 after reset", int'(wake_pulse), 0);
        armed = 1'b1;
        repeat (4) @(negedge clk);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            open_window();
            if (VECS[i].kind == 2'd0) bus_run(int'(VECS[i].len));
            else                      pin_run(int'(VECS[i].len));
            close_window();
            check($sformatf("R%0d vector %0d", VECS[i].req, i), seen, int'(VECS[i].exp));
        end

        // R2: exact latency of the remote wake after the bus returns to recessive.
        bus_run(BUS_LIM);
        @(negedge clk) check("R2 latency edge 1", int'(wake_pulse), 0);
        @(negedge clk) check("R2 latency edge 2", int'(wake_pulse), 0);
        @(negedge clk) check("R2 latency edge 3", int'(wake_pulse), 1);
        @(negedge clk) check("R2 pulse ends", int'(wake_pulse), 0);
        repeat (4) @(negedge clk);

        // R6: exact latency of the local wake.
        @(negedge clk) wake_pin_n = 1'b0;
        repeat (PIN_LIM + 2) @(negedge clk);
        check("R6 before latency", int'(wake_pulse), 0);
        @(negedge clk) check("R6 at latency", int'(wake_pulse), 1);
        wake_pin_n = 1'b1;
        repeat (6) @(negedge clk);

        // R4: a bus stuck dominant never wakes; release it while disarmed.
        open_window();
        bus_level = 1'b0;
        repeat (500) @(negedge clk);
        armed = 1'b0;
        @(negedge clk) bus_level = 1'b1;
        repeat (5) @(negedge clk);
        armed = 1'b1;
        close_window();
        check("R4 stuck dominant", seen, 0);

        // R5: bus already dominant at arming; its return does not wake.
        armed = 1'b0;
        open_window();
        bus_level = 1'b0;
        repeat (4) @(negedge clk);
        armed = 1'b1;
        repeat (20) @(negedge clk);
        bus_level = 1'b1;
        close_window();
        check("R5 no falling transition", seen, 0);

        // R8: disarmed pin press is ignored.
        armed = 1'b0;
        open_window();
        pin_run(20);
        close_window();
        check("R8 disarmed pin", seen, 0);
        armed = 1'b1;
        repeat (4) @(negedge clk);

        // R8: a dominant run interrupted by disarming does not count.
        open_window();
        bus_level = 1'b0;
        repeat (5) @(negedge clk);
        armed = 1'b0;
        @(negedge clk) armed = 1'b1;
        repeat (5) @(negedge clk);
        bus_level = 1'b1;
        close_window();
        check("R8 interrupted run", seen, 0);

        // R10: a lower bus limit takes effect.
        armed = 1'b0;
        bus_min_cycles = CNT_W'(3);
        @(negedge clk) armed = 1'b1;
        repeat (4) @(negedge clk);
        open_window();
        bus_run(3);
        close_window();
        check("R10 run at new limit", seen, 1);
        open_window();
        bus_run(2);
        close_window();
        check("R10 run below new limit", seen, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule